// File: doc/BRIEF.md
# Receiver Control Line Override

This block sits between the receiver sequencing logic and eight receiver control pins. The host sends it 32-bit command words that a serial front end has already assembled, each marked by a one-cycle strobe. One command type lets the host take over any subset of the control lines. That command carries a per-line force mask and a per-line drive value. Every other command type passes by untouched.

For each line, the pin carries the internal sequencer's value when the line is not forced, and the host's value when it is. The mask and the value are captured together in one clock edge, so no line ever shows a new mask combined with an old value. While the synchronous reset is held, every pin is released to high impedance. The pin drivers turn on at the first clock edge after reset is released.

Top module: `rx_line_override`

## Requirements
- R1: After reset both stored fields are zero, so every enabled pin equals the matching `int_lines` bit until an override command is accepted.
- R2: Any clock edge with `rst_n` low turns `ctl_oe` off, and all eight `ctl_lines` pins float.
- R3: At the first clock edge with `rst_n` high, `ctl_oe` turns on. It stays on until reset is asserted again.
- R4: An override command is a word with `cmd_valid` high, bits [31:24] equal to 0x0F and bits [23:16] equal to zero. At the next edge the block stores bits [15:8] as the force mask and bits [7:0] as the drive value.
- R5: A line whose force-mask bit is 1 drives the stored drive-value bit, whatever its internal value is.
- R6: A line whose force-mask bit is 0 follows its `int_lines` bit combinationally. The drive-value bit for that line has no effect.
- R7: A valid word with any identifier other than 0x0F leaves both stored fields unchanged.
- R8: A word with identifier 0x0F but a nonzero bits [23:16] is discarded. Both stored fields keep their contents.
- R9: While `cmd_valid` is low, `cmd_word` is ignored.
- R10: Accepting a later command whose mask bit for a line is 0 gives that line back to `int_lines`.
- R11: The mask and the value change in the same cycle. In the cycle where the command is presented, the old override is still shown. From the next cycle on, the new one is shown on all lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 32 | Command word: [31:24] identifier, [23:16] reserved zero, [15:8] force mask, [7:0] drive value |
| int_lines | input | 8 | Line values from the internal receiver sequencer |
| ctl_lines | output | 8 | Receiver control pins, high impedance while disabled |
| ctl_oe | output | 1 | Pin driver enable |

## Verification
A command presented before a rising edge is stored at that edge. Its effect on the pins is therefore due one cycle after the strobe. A change on `int_lines` reaches an unforced pin in the same cycle, and `ctl_oe` follows `rst_n` at the next edge. The bench changes inputs only on falling edges and samples on the following falling edge. This places every comparison exactly one edge after a registered stimulus, or within the same cycle for combinational paths. The atomic-update check also samples the cycle in which the strobe is high, to confirm the old override is still in place.

// File: rtl/rlo_pkg.sv
// Package: shared constants for the receiver control line override.
// Assumes a command word made of four equal fields, one per line group.
package rlo_pkg;
    // Field positions inside a command word, least significant first.
    localparam int unsigned FLD_VALUE = 0;
    localparam int unsigned FLD_MASK  = 1;
    localparam int unsigned FLD_RSVD  = 2;
    localparam int unsigned FLD_ID    = 3;
    localparam int unsigned NUM_FLDS  = 4;

    // Pin driver state, held in a register cleared by reset.
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_state_e;
endpackage

// File: rtl/rlo_cmd_decode.sv
// Module: rlo_cmd_decode
// Splits a command word into fields. It raises a load strobe only for a
// valid word whose identifier matches CMD_ID and whose reserved field is zero.
// Assumes cmd_valid is high for exactly one cycle per command word.
module rlo_cmd_decode
    import rlo_pkg::*;
#(
    parameter int unsigned      LINES  = 8,
    parameter logic [LINES-1:0] CMD_ID = 'h0F,
    localparam int unsigned     WORD_W = NUM_FLDS * LINES
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              load,
    output logic [LINES-1:0]  mask_in,
    output logic [LINES-1:0]  value_in
);
    logic [LINES-1:0] fld [NUM_FLDS];

    // Slice the word into equal-width fields.
    for (genvar f = 0; f < NUM_FLDS; f++) begin : g_fld
        assign fld[f] = cmd_word[f*LINES +: LINES];
    end

    // Accept only a matching identifier with a clean reserved field.
    always_comb begin
        load     = cmd_valid && (fld[FLD_ID] == CMD_ID) && (fld[FLD_RSVD] == '0);
        mask_in  = fld[FLD_MASK];
        value_in = fld[FLD_VALUE];
    end
endmodule

// File: rtl/rlo_force_regs.sv
// Module: rlo_force_regs
// Holds the force mask and the drive value, and loads both in one edge.
// Also holds the pin driver state: off during reset, on otherwise.
// Assumes a synchronous active-low reset.
module rlo_force_regs
    import rlo_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LINES-1:0] mask_in,
    input  logic [LINES-1:0] value_in,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] value_q,
    output logic             oe
);
    drv_state_e drv_q;

    // Capture mask and value together on an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            value_q <= '0;
        end else if (load) begin
            mask_q  <= mask_in;
            value_q <= value_in;
        end
    end

    // Track the driver state from the reset level.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= DRV_OFF;
        else        drv_q <= DRV_ON;
    end

    assign oe = (drv_q == DRV_ON);
endmodule

// File: rtl/rlo_line_mux.sv
// Module: rlo_line_mux
// For each line, picks the host value or the internal value, then drives
// the pin only while the enable is on.
// Assumes mask and value come from registers that load together.
module rlo_line_mux #(
    parameter int unsigned LINES = 8
) (
    input  logic             oe,
    input  logic [LINES-1:0] mask_q,
    input  logic [LINES-1:0] value_q,
    input  logic [LINES-1:0] int_lines,
    output logic [LINES-1:0] drive,
    output wire  [LINES-1:0] pins
);
    // One selector and one tristate buffer per line.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign drive[i] = mask_q[i] ? value_q[i] : int_lines[i];
        assign pins[i]  = oe ? drive[i] : 1'bz;
    end
endmodule

// File: rtl/rx_line_override.sv
// Module: rx_line_override (top)
// Host override of the receiver control lines. The top module connects the
// decoder, the registers and the line mux.
// Assumes the command words are already assembled from the serial host link.
module rx_line_override
    import rlo_pkg::*;
#(
    parameter int unsigned      LINES  = 8,
    parameter logic [LINES-1:0] CMD_ID = 'h0F,
    localparam int unsigned     WORD_W = NUM_FLDS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [LINES-1:0]  int_lines,
    output wire  [LINES-1:0]  ctl_lines,
    output logic              ctl_oe
);
    logic             load;
    logic [LINES-1:0] mask_in, value_in, mask_q, value_q, line_drive;

    rlo_cmd_decode #(.LINES(LINES), .CMD_ID(CMD_ID)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .load      (load),
        .mask_in   (mask_in),
        .value_in  (value_in)
    );

    rlo_force_regs #(.LINES(LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mask_in  (mask_in),
        .value_in (value_in),
        .mask_q   (mask_q),
        .value_q  (value_q),
        .oe       (ctl_oe)
    );

    rlo_line_mux #(.LINES(LINES)) u_mux (
        .oe        (ctl_oe),
        .mask_q    (mask_q),
        .value_q   (value_q),
        .int_lines (int_lines),
        .drive     (line_drive),
        .pins      (ctl_lines)
    );
endmodule

// File: rtl/rlo_checker.sv
// Module: rlo_checker
// Properties for rx_line_override. It is bound into the top module and
// observes its ports and stored fields.
module rlo_checker
    import rlo_pkg::*;
#(
    parameter int unsigned      LINES  = 8,
    parameter logic [LINES-1:0] CMD_ID = 'h0F,
    localparam int unsigned     WORD_W = NUM_FLDS * LINES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic [LINES-1:0]  int_lines,
    input logic              ctl_oe,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  value_q,
    input logic [LINES-1:0]  line_drive
);
    logic [LINES-1:0] w_id, w_rsvd;
    assign w_id   = cmd_word[FLD_ID*LINES +: LINES];
    assign w_rsvd = cmd_word[FLD_RSVD*LINES +: LINES];

    assert_off_in_reset_R2: assert property (@(posedge clk)
        !rst_n |=> !ctl_oe);

    assert_on_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ctl_oe);

    assert_load_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && w_id == CMD_ID && w_rsvd == '0) |=>
        (mask_q == $past(cmd_word[FLD_MASK*LINES +: LINES]) &&
         value_q == $past(cmd_word[FLD_VALUE*LINES +: LINES])));

    assert_forced_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_drive ^ value_q) & mask_q) == '0);

    assert_free_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_drive ^ int_lines) & ~mask_q) == '0);

    assert_other_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && w_id != CMD_ID) |=> ($stable(mask_q) && $stable(value_q)));

    assert_bad_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && w_rsvd != '0) |=> ($stable(mask_q) && $stable(value_q)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(mask_q) && $stable(value_q)));
endmodule

bind rx_line_override rlo_checker #(.LINES(LINES), .CMD_ID(CMD_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .int_lines  (int_lines),
    .ctl_oe     (ctl_oe),
    .mask_q     (mask_q),
    .value_q    (value_q),
    .line_drive (line_drive)
);

// File: tb/rx_line_override_tb.sv
module rx_line_override_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [7:0]  int_lines = '0;
    wire  [7:0]  ctl_lines;
    logic        ctl_oe;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] m_mask = '0, m_val = '0;   // expected stored fields

    always #2 clk = ~clk;

    rx_line_override u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .int_lines(int_lines), .ctl_lines(ctl_lines), .ctl_oe(ctl_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_lines();
        return (int_lines & ~m_mask) | (m_val & m_mask);
    endfunction

    task automatic check_lines(input string req);
        check(ctl_oe === 1'b1 && ctl_lines === expect_lines(), req, {23'd0, ctl_oe, ctl_lines}, {24'd1, expect_lines()});
    endtask

    // Present one word for one cycle; returns at the next falling edge.
    task automatic send(input logic v, input logic [31:0] w);
        cmd_valid = v;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v && w[31:24] == 8'h0F && w[23:16] == 8'h00) begin
            m_mask = w[15:8];
            m_val  = w[7:0];
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(ctl_oe === 1'b0, "R2 enable off in reset", {31'd0, ctl_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_oe === 1'b1, "R3 enable on after reset", {31'd0, ctl_oe}, 32'd1);
        int_lines = 8'h3C;
        #0.5;
        check_lines("R1 lines follow internal after reset");
    endtask

    task automatic t_force();
        int_lines = 8'h00;
        send(1'b1, 32'h0F00_F0A5);
        check_lines("R4 R5 forced nibble");
        int_lines = 8'hFF;
        #0.5;
        check_lines("R5 forced bits hold against internal");
    endtask

    task automatic t_free_ignores_value();
        send(1'b1, 32'h0F00_0FFF);
        int_lines = 8'h00;
        #0.5;
        check_lines("R6 unforced upper lines ignore value bits");
        int_lines = 8'h50;
        #0.5;
        check_lines("R6 unforced lines track internal");
    endtask

    task automatic t_other_id();
        send(1'b1, 32'h0E00_FF00);
        check_lines("R7 id 0x0E ignored");
        send(1'b1, 32'h8F00_FF00);
        check_lines("R7 id 0x8F ignored");
    endtask

    task automatic t_bad_rsvd();
        send(1'b1, 32'h0F01_FF00);
        check_lines("R8 nonzero reserved field discarded");
    endtask

    task automatic t_idle();
        send(1'b0, 32'h0F00_FF00);
        check_lines("R9 word without strobe ignored");
    endtask

    task automatic t_release();
        int_lines = 8'hAA;
        send(1'b1, 32'h0F00_FF55);
        check_lines("R5 all lines forced");
        send(1'b1, 32'h0F00_0055);
        check_lines("R10 lines returned to internal");
    endtask

    task automatic t_atomic();
        int_lines = 8'h0F;
        send(1'b1, 32'h0F00_3300);
        cmd_valid = 1'b1;
        cmd_word  = 32'h0F00_CCCC;
        #0.5;
        check_lines("R11 old override kept while strobe high");
        @(negedge clk);
        cmd_valid = 1'b0;
        m_mask = 8'hCC;
        m_val  = 8'hCC;
        check_lines("R11 new override on all lines next cycle");
    endtask

    task automatic t_reset_again();
        send(1'b1, 32'h0F00_FFA5);
        rst_n = 1'b0;
        @(negedge clk);
        check(ctl_oe === 1'b0, "R2 enable off on later reset", {31'd0, ctl_oe}, 32'd0);
        rst_n = 1'b1;
        m_mask = '0;
        m_val  = '0;
        int_lines = 8'h96;
        @(negedge clk);
        check_lines("R1 fields cleared by reset");
    endtask

    initial begin
        t_reset();
        t_force();
        t_free_ignores_value();
        t_other_id();
        t_bad_rsvd();
        t_idle();
        t_release();
        t_atomic();
        t_reset_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule